// File: doc/BRIEF.md
# Privileged Diagnostic-Register Move Decoder

This block watches an instruction byte stream that arrives one byte per clock with a valid strobe. It picks out the two-byte-opcode moves that copy a value between a general-purpose register and a small bank of 32-bit diagnostic registers. The block holds that bank itself. It performs the move through a simple port to an eight-entry general-purpose register file: a combinational read index and data pair, and a one-cycle write strobe with an index and data.

A move is the escape byte 0x0F, then an opcode byte, then a ModR/M byte. Opcode 0x26 copies a general-purpose register into a diagnostic register. Opcode 0x24 copies the other way. In the ModR/M byte, bits 5:3 select the diagnostic register and bits 2:0 select the general-purpose register. Only the register form (bits 7:6 equal to binary 11) is legal.

Before it executes, the block checks the processor mode, the current privilege level, the addressing form and whether the configured generation implements the selected index. It then gives one of two results for one cycle: a completion pulse, or a fault pulse with a code. If the byte after the escape is not one of its two opcodes, the block gives up the sequence quietly with a "not mine" pulse.

Top module: `diagreg_move_unit`

## Requirements
- R1: After 0x0F, 0x26 and a legal ModR/M byte, `done` is high for the one cycle after the ModR/M byte is accepted. The value on `gpr_rd_data`, read at index ModR/M[2:0], is stored into the diagnostic register selected by ModR/M[5:3] on the clock edge that ends that cycle.
- R2: After 0x0F, 0x24 and a legal ModR/M byte, the completion cycle also drives `gpr_wr_en`=1, `gpr_wr_idx`=ModR/M[2:0] and `gpr_wr_data` equal to the current value of the selected diagnostic register. `gpr_wr_en` is never high without `done`.
- R3: With `prot_mode`=0 (real-address mode), both directions execute whatever the value of `cpl`.
- R4: With `prot_mode`=1 and `cpl` not 0, either direction gives `fault`=1 with `fault_code`=2'b01 (general protection). No register is changed. This check wins over R5 and R6.
- R5: A ModR/M byte whose bits 7:6 are not 2'b11 gives `fault`=1 with `fault_code`=2'b10 (invalid opcode). No register is changed.
- R6: With `gen_new`=1, indices 3 to 7 are implemented. With `gen_new`=0, only 6 and 7 are. Any other index gives `fault_code`=2'b10, and no register is changed.
- R7: If the byte after 0x0F is anything other than 0x24 or 0x26, `not_mine` is high during the cycle that byte is presented. No fault is raised, and the decoder goes back to waiting for 0x0F.
- R8: Bytes presented with `byte_vld`=0 are ignored, so gaps between the bytes of a move are allowed. In the idle state, valid bytes other than 0x0F are ignored.
- R9: A synchronous `rst` clears every diagnostic register to zero and returns the decoder to idle. While in reset, all outputs are low.
- R10: `done` and `fault` never occur together, and each lasts exactly one cycle. `fault_code` is 2'b00 whenever `fault` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | `byte_in` carries an instruction byte this cycle |
| byte_in | input | 8 | Instruction stream byte |
| prot_mode | input | 1 | 1 = protected mode, 0 = real-address mode |
| cpl | input | 2 | Current privilege level |
| gen_new | input | 1 | 1 = diagnostic indices 3..7 implemented, 0 = only 6..7 |
| gpr_rd_idx | output | 3 | General-purpose register read index (ModR/M[2:0]) |
| gpr_rd_data | input | 32 | Combinational read data from the register file |
| gpr_wr_en | output | 1 | Register-file write strobe for a read-out move |
| gpr_wr_idx | output | 3 | Register-file write index |
| gpr_wr_data | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 00 none, 01 general protection, 10 invalid opcode |
| not_mine | output | 1 | Sequence abandoned: the opcode is not one of this block's two |

## Verification
A decoder stuck in the wrong state shows up at the ports within one to three bytes. Three symptoms are possible: a missing or extra `done`, a `not_mine` pulse on a good opcode, or a result pulse that arrives a cycle early or late. Corruption in the diagnostic bank cannot be seen until the next read-out move, so the bench writes a value and reads it back. It also re-reads a register after every faulting write aimed at it, which exposes a commit that should have been blocked. A wrong priority among the checks shows immediately as the wrong `fault_code` on stimulus that breaks two rules at once.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ESC  = 2'd1,
        ST_OPC  = 2'd2,
        ST_EXEC = 2'd3
    } dec_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_UD   = 2'b10
    } fault_e;

    localparam logic [7:0] ESC_BYTE     = 8'h0F;
    localparam logic [7:0] OP_TO_DIAG   = 8'h26;
    localparam logic [7:0] OP_FROM_DIAG = 8'h24;
    localparam logic [1:0] MOD_REG      = 2'b11;
    localparam int         FIELD_W      = 3;

    typedef struct packed {
        dec_state_e  st;
        logic        to_diag;
        logic [7:0]  modrm;
    } dec_regs_t;

endpackage

// File: rtl/diag_byte_fsm.sv
module diag_byte_fsm
    import diag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       in_exec,
    output logic       to_diag,
    output logic [7:0] modrm,
    output logic       not_mine
);

    dec_regs_t dec_d, dec_q;

    always_comb begin
        dec_d    = dec_q;
        not_mine = 1'b0;
        case (dec_q.st)
            ST_IDLE: begin
                if (byte_vld && byte_in == ESC_BYTE) dec_d.st = ST_ESC;
            end
            ST_ESC: begin
                if (byte_vld) begin
                    if (byte_in == OP_TO_DIAG) begin
                        dec_d.st      = ST_OPC;
                        dec_d.to_diag = 1'b1;
                    end else if (byte_in == OP_FROM_DIAG) begin
                        dec_d.st      = ST_OPC;
                        dec_d.to_diag = 1'b0;
                    end else begin
                        dec_d.st = ST_IDLE;
                        not_mine = 1'b1;
                    end
                end
            end
            ST_OPC: begin
                if (byte_vld) begin
                    dec_d.modrm = byte_in;
                    dec_d.st    = ST_EXEC;
                end
            end
            ST_EXEC: dec_d.st = ST_IDLE;
            default: dec_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '{st: ST_IDLE, to_diag: 1'b0, modrm: 8'h00};
        else     dec_q <= dec_d;
    end

    assign in_exec = (dec_q.st == ST_EXEC);
    assign to_diag = dec_q.to_diag;
    assign modrm   = dec_q.modrm;

endmodule

// File: rtl/diag_access_check.sv
module diag_access_check
    import diag_pkg::*;
#(
    parameter int NEW_LO = 3,
    parameter int OLD_LO = 6,
    parameter int HI_IDX = 7
) (
    input  logic               in_exec,
    input  logic               prot_mode,
    input  logic [1:0]         cpl,
    input  logic               gen_new,
    input  logic [1:0]         mod_fld,
    input  logic [FIELD_W-1:0] reg_fld,
    output logic               ok,
    output logic               fault,
    output logic [1:0]         fault_code
);

    localparam int SLOTS = 1 << FIELD_W;

    function automatic logic [SLOTS-1:0] impl_mask(input int lo, input int hi);
        logic [SLOTS-1:0] m;
        for (int i = 0; i < SLOTS; i++) m[i] = (i >= lo) && (i <= hi);
        return m;
    endfunction

    localparam logic [SLOTS-1:0] NEW_MASK = impl_mask(NEW_LO, HI_IDX);
    localparam logic [SLOTS-1:0] OLD_MASK = impl_mask(OLD_LO, HI_IDX);

    logic gp_hit, ud_hit, implemented;

    always_comb begin
        implemented = gen_new ? NEW_MASK[reg_fld] : OLD_MASK[reg_fld];
        gp_hit      = prot_mode && (cpl != 2'd0);
        ud_hit      = (mod_fld != MOD_REG) || !implemented;
        ok          = in_exec && !gp_hit && !ud_hit;
        fault       = in_exec && (gp_hit || ud_hit);
        if (!fault)      fault_code = FLT_NONE;
        else if (gp_hit) fault_code = FLT_GP;
        else             fault_code = FLT_UD;
    end

endmodule

// File: rtl/diag_reg_bank.sv
module diag_reg_bank
    import diag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LO_IDX = 3,
    parameter int HI_IDX = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] idx,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int N = HI_IDX - LO_IDX + 1;

    logic [N-1:0][DATA_W-1:0] slots;

    for (genvar g = 0; g < N; g++) begin : g_slot
        localparam logic [FIELD_W-1:0] SLOT_IDX = FIELD_W'(LO_IDX + g);
        logic [DATA_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && idx == SLOT_IDX) slot_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q <= '0;
            else     slot_q <= slot_d;
        end

        assign slots[g] = slot_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (idx == FIELD_W'(LO_IDX + i)) rd_data = slots[i];
    end

endmodule

// File: rtl/diagreg_move_unit.sv
module diagreg_move_unit
    import diag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NEW_LO = 3,
    parameter int OLD_LO = 6,
    parameter int HI_IDX = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              prot_mode,
    input  logic [1:0]        cpl,
    input  logic              gen_new,
    output logic [2:0]        gpr_rd_idx,
    input  logic [DATA_W-1:0] gpr_rd_data,
    output logic              gpr_wr_en,
    output logic [2:0]        gpr_wr_idx,
    output logic [DATA_W-1:0] gpr_wr_data,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic              not_mine
);

    logic              in_exec, to_diag, move_ok;
    logic [7:0]        modrm;
    logic [DATA_W-1:0] bank_rd;

    diag_byte_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .in_exec  (in_exec),
        .to_diag  (to_diag),
        .modrm    (modrm),
        .not_mine (not_mine)
    );

    diag_access_check #(
        .NEW_LO (NEW_LO),
        .OLD_LO (OLD_LO),
        .HI_IDX (HI_IDX)
    ) u_chk_acc (
        .in_exec    (in_exec),
        .prot_mode  (prot_mode),
        .cpl        (cpl),
        .gen_new    (gen_new),
        .mod_fld    (modrm[7:6]),
        .reg_fld    (modrm[5:3]),
        .ok         (move_ok),
        .fault      (fault),
        .fault_code (fault_code)
    );

    diag_reg_bank #(
        .DATA_W (DATA_W),
        .LO_IDX (NEW_LO),
        .HI_IDX (HI_IDX)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (move_ok && to_diag),
        .idx     (modrm[5:3]),
        .wr_data (gpr_rd_data),
        .rd_data (bank_rd)
    );

    assign gpr_rd_idx  = modrm[2:0];
    assign gpr_wr_idx  = modrm[2:0];
    assign gpr_wr_en   = move_ok && !to_diag;
    assign gpr_wr_data = bank_rd;
    assign done        = move_ok;

endmodule

// File: rtl/diagreg_move_chk.sv
module diagreg_move_chk (
    input logic       clk,
    input logic       rst,
    input logic       prot_mode,
    input logic [1:0] cpl,
    input logic       gpr_wr_en,
    input logic       done,
    input logic       fault,
    input logic [1:0] fault_code,
    input logic       not_mine
);

    // R10
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    fault_single_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    // R10
    code_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |-> fault_code == 2'b00);

    // R4
    gp_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && prot_mode && cpl != 2'd0) |-> fault_code == 2'b01);

    // R4
    no_done_when_unpriv_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_mode && cpl != 2'd0) |-> !done);

    // R2
    wr_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        gpr_wr_en |-> done);

    // R7
    not_mine_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        not_mine |-> (!done && !fault));

    // R7
    not_mine_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        not_mine |=> (!done && !fault));

endmodule

bind diagreg_move_unit diagreg_move_chk u_move_chk (.*);

// File: tb/tb_diagreg_move_unit.sv
module tb_diagreg_move_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        prot_mode = 1'b1;
    logic [1:0]  cpl = 2'd0;
    logic        gen_new = 1'b1;
    logic [2:0]  gpr_rd_idx, gpr_wr_idx;
    logic [31:0] gpr_rd_data, gpr_wr_data;
    logic        gpr_wr_en, done, fault, not_mine;
    logic [1:0]  fault_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    diagreg_move_unit dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .prot_mode(prot_mode), .cpl(cpl), .gen_new(gen_new),
        .gpr_rd_idx(gpr_rd_idx), .gpr_rd_data(gpr_rd_data),
        .gpr_wr_en(gpr_wr_en), .gpr_wr_idx(gpr_wr_idx), .gpr_wr_data(gpr_wr_data),
        .done(done), .fault(fault), .fault_code(fault_code), .not_mine(not_mine)
    );

    // Register-file model: reset fills entry i with C0DE_0000 + i
    logic [31:0] gpr_m [8];
    assign gpr_rd_data = gpr_m[gpr_rd_idx];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) gpr_m[i] <= 32'hC0DE_0000 + 32'(i);
        end else if (gpr_wr_en) begin
            gpr_m[gpr_wr_idx] <= gpr_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic        s_done, s_fault, s_wr, s_done2, s_fault2;
    logic [1:0]  s_code;
    logic [2:0]  s_widx;
    logic [31:0] s_wdata;

    task automatic run_move(input bit wr, input logic [7:0] mrm, input bit pm,
                            input logic [1:0] lvl, input bit gen);
        @(negedge clk);
        prot_mode = pm; cpl = lvl; gen_new = gen;
        byte_vld = 1'b1; byte_in = 8'h0F;
        @(negedge clk);
        byte_in = wr ? 8'h26 : 8'h24;
        @(negedge clk);
        byte_in = mrm;
        @(negedge clk);
        byte_vld = 1'b0; byte_in = 8'h00;
        #1;
        s_done = done; s_fault = fault; s_code = fault_code;
        s_wr = gpr_wr_en; s_widx = gpr_wr_idx; s_wdata = gpr_wr_data;
        @(negedge clk);
        #1;
        s_done2 = done; s_fault2 = fault;
    endtask

    task automatic put_byte(input bit v, input logic [7:0] b);
        @(negedge clk);
        byte_vld = v; byte_in = b;
    endtask

    typedef struct packed {
        logic        wr;
        logic [7:0]  mrm;
        logic        pm;
        logic [1:0]  lvl;
        logic        gen;
        logic [1:0]  code;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hF1, 1'b1, 2'd0, 1'b1, 2'b00, 32'h0},          // R1 write 6 <- r1
        '{1'b0, 8'hF2, 1'b1, 2'd0, 1'b1, 2'b00, 32'hC0DE_0001},  // R2 read 6 -> r2
        '{1'b1, 8'hDC, 1'b1, 2'd0, 1'b1, 2'b00, 32'h0},          // R6 write 3 on new gen
        '{1'b0, 8'hDD, 1'b1, 2'd0, 1'b1, 2'b00, 32'hC0DE_0004},  // R2 read 3
        '{1'b1, 8'hFB, 1'b1, 2'd3, 1'b1, 2'b01, 32'h0},          // R4 cpl 3 write
        '{1'b0, 8'hF8, 1'b0, 2'd3, 1'b1, 2'b00, 32'h0},          // R3 real mode, 7 untouched
        '{1'b1, 8'hE9, 1'b1, 2'd0, 1'b0, 2'b10, 32'h0},          // R6 index 5 on old gen
        '{1'b0, 8'hDE, 1'b1, 2'd0, 1'b0, 2'b10, 32'h0},          // R6 index 3 on old gen
        '{1'b1, 8'hC1, 1'b1, 2'd0, 1'b1, 2'b10, 32'h0},          // R6 index 0
        '{1'b1, 8'hB1, 1'b1, 2'd0, 1'b1, 2'b10, 32'h0},          // R5 mod 10
        '{1'b1, 8'h01, 1'b1, 2'd1, 1'b1, 2'b01, 32'h0},          // R4 beats R5 and R6
        '{1'b0, 8'h70, 1'b0, 2'd2, 1'b0, 2'b10, 32'h0},          // R5 mod 01 in real mode
        '{1'b0, 8'hDE, 1'b1, 2'd0, 1'b1, 2'b00, 32'hC0DE_0004},  // R6 3 kept after faults
        '{1'b0, 8'hEF, 1'b1, 2'd0, 1'b1, 2'b00, 32'h0},          // R6 5 kept after fault
        '{1'b0, 8'hF8, 1'b1, 2'd0, 1'b1, 2'b00, 32'h0},          // R4 7 kept after GP
        '{1'b1, 8'hFA, 1'b0, 2'd1, 1'b1, 2'b00, 32'h0},          // R3 write 7 in real mode
        '{1'b0, 8'hFC, 1'b1, 2'd0, 1'b1, 2'b00, 32'hC0DE_0001},  // R3 read back 7
        '{1'b1, 8'hF7, 1'b1, 2'd0, 1'b0, 2'b00, 32'h0},          // R6 write 6 on old gen
        '{1'b0, 8'hF3, 1'b1, 2'd0, 1'b0, 2'b00, 32'h0}           // R6 read 6 on old gen
    };

    bit finished = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(done == 0 && fault == 0 && not_mine == 0 && gpr_wr_en == 0,
            "R9", "outputs low in reset", {done, fault, not_mine, gpr_wr_en}, 0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            bit   exp_done;
            v = VECS[k];
            exp_done = (v.code == 2'b00);
            run_move(v.wr, v.mrm, v.pm, v.lvl, v.gen);
            chk(s_done == exp_done, "R1", $sformatf("vec %0d done", k), 32'(s_done), 32'(exp_done));
            chk(s_fault == !exp_done, "R10", $sformatf("vec %0d fault", k), 32'(s_fault), 32'(!exp_done));
            chk(s_code == v.code, "R4", $sformatf("vec %0d fault_code", k), 32'(s_code), 32'(v.code));
            chk(s_wr == (exp_done && !v.wr), "R2", $sformatf("vec %0d gpr_wr_en", k),
                32'(s_wr), 32'(exp_done && !v.wr));
            chk(s_done2 == 0 && s_fault2 == 0, "R10", $sformatf("vec %0d single pulse", k),
                32'({s_done2, s_fault2}), 0);
            if (exp_done && !v.wr) begin
                chk(s_widx == v.mrm[2:0], "R2", $sformatf("vec %0d gpr_wr_idx", k),
                    32'(s_widx), 32'(v.mrm[2:0]));
                chk(s_wdata == v.data, "R2", $sformatf("vec %0d gpr_wr_data", k), s_wdata, v.data);
            end
        end

        // R7: foreign opcode after escape
        prot_mode = 1'b1; cpl = 2'd0; gen_new = 1'b1;
        put_byte(1'b1, 8'h0F);
        put_byte(1'b1, 8'h20);
        #2;
        chk(not_mine == 1 && fault == 0 && done == 0, "R7", "not_mine pulse",
            32'({not_mine, fault, done}), 32'b100);
        put_byte(1'b0, 8'h00);
        #2;
        chk(not_mine == 0, "R7", "not_mine one cycle", 32'(not_mine), 0);
        // R7: a second escape as the opcode byte is also foreign
        put_byte(1'b1, 8'h0F);
        put_byte(1'b1, 8'h0F);
        #2;
        chk(not_mine == 1, "R7", "escape twice", 32'(not_mine), 1);
        put_byte(1'b0, 8'h00);
        run_move(1'b0, 8'hF0, 1'b1, 2'd0, 1'b1);
        chk(s_done == 1 && s_wdata == 32'h0, "R7", "decoder idle after not_mine", s_wdata, 0);

        // R8: stray bytes in idle are ignored
        put_byte(1'b1, 8'h26);
        put_byte(1'b1, 8'hF1);
        put_byte(1'b1, 8'hF1);
        #2;
        chk(done == 0 && fault == 0 && not_mine == 0, "R8", "no escape no move",
            32'({done, fault, not_mine}), 0);
        put_byte(1'b0, 8'h00);

        // R8: gaps with invalid bytes between the bytes of a write to 6
        put_byte(1'b1, 8'h0F);
        put_byte(1'b0, 8'h24);
        put_byte(1'b1, 8'h26);
        put_byte(1'b0, 8'hFF);
        put_byte(1'b1, 8'hF1);
        put_byte(1'b0, 8'h00);
        #1;
        chk(done == 1 && gpr_wr_en == 0, "R8", "stalled write completes",
            32'({done, gpr_wr_en}), 32'b10);
        run_move(1'b0, 8'hF5, 1'b1, 2'd0, 1'b1);
        chk(s_wdata == 32'hC0DE_0001, "R8", "stalled write value", s_wdata, 32'hC0DE_0001);

        // R9: reset clears the bank
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_move(1'b0, 8'hF5, 1'b1, 2'd0, 1'b1);
        chk(s_done == 1 && s_wdata == 32'h0, "R9", "index 6 cleared", s_wdata, 0);
        run_move(1'b0, 8'hDD, 1'b1, 2'd0, 1'b1);
        chk(s_done == 1 && s_wdata == 32'h0, "R9", "index 3 cleared", s_wdata, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule